// File: doc/BRIEF.md
# Register-Driven SPI Command Engine

This block is a half-duplex SPI master that software drives through a small byte-wide register space. Software loads an opcode, a transmit count, a receive count and a chip-select number, and places the outgoing payload in a shared byte buffer. A write to the trigger register starts the command. The engine drops the chosen chip select and shifts out the opcode, then the payload bytes. It then clocks in the requested number of reply bytes and writes them into the same buffer, directly after the payload. Software polls the busy flag and reads the reply from the buffer.

The opcode comes from its own register and is not part of the buffer or of the transmit count. An internal buffer pointer walks the buffer: each payload byte fetched and each reply byte stored moves it on by one. Software normally resets the pointer to zero before each command, so reply byte j lands at buffer offset tx_count + j. The serial clock runs in SPI mode 0 at the system clock divided by an even parameter.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, busy reads 0, every cs_n line is high, sclk and mosi are low, and the opcode, count, chip-select and status bytes read 0.
- R2: Byte registers: opcode at 0x45, transmit count at 0x48, receive count at 0x4B, chip-select number in bits 1:0 of 0x1D (bits 7:2 read 0). Buffer byte i is written and read at 0x80+i, for i below BUF_BYTES.
- R3: Writing a byte with bit 7 set to 0x47 while idle starts a command. Busy is bit 7 of byte 0x4F (bit 31 of the status word at 0x4C). It reads 1 from the cycle after the trigger write until the last reply byte has been stored.
- R4: The stream sends the opcode first, then the payload bytes from buffer[ptr], buffer[ptr+1], and so on, each byte MSB first. sclk idles low, mosi changes only while sclk is low, miso is sampled on the rising edge, and consecutive rising edges are CLK_DIV clocks apart for the whole command.
- R5: Reply bytes are assembled MSB first from miso. Reply byte j is stored at buffer offset ptr_start + tx_eff + j (mod BUF_BYTES), which is 0x80 + tx_count + j after a pointer clear.
- R6: During a command, only cs_n[sel] is low, where sel is the chip-select number. It stays low for one unbroken stretch that covers the opcode, the payload and the reply.
- R7: Half duplex: mosi is 0 during every reply byte, and miso is ignored while the opcode and payload are shifted, so the payload bytes in the buffer are not changed.
- R8: A transmit count of 0 sends only the opcode. A receive count of 0 ends the command right after the last payload byte.
- R9: Counts are truncated to fit the buffer: tx_eff = min(tx_count, BUF_BYTES) and rx_eff = min(rx_count, BUF_BYTES - tx_eff). The command lasts exactly 8*(1+tx_eff+rx_eff) serial clocks.
- R10: Writing a byte with bit 4 set to 0x02 (bit 20 of the control word at 0x00) while idle resets the buffer pointer to 0. Without a clear, the next command starts where the previous one left the pointer: at (start + tx_eff + rx_eff) mod BUF_BYTES.
- R11: While busy, a trigger, a pointer clear and any buffer write are ignored. Register writes are accepted but do not change the command in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Byte write strobe |
| bus_addr | input | 8 | Byte address for write and read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NCS | Active-low chip selects |

## Verification
The in-design properties check on every cycle that exactly one chip select is low while busy and that it never changes mid-command. They also check that mosi holds while sclk is high, that mosi is low in the reply phase, that the shifter and the sequencer agree on busy, that the pointer stays inside the buffer, and that the truncated counts fit. They confirm that busy only falls after a reply store. Only the bench scenarios can show that the right bytes arrive in the right order, that replies land at the right offsets, and that the pointer continues when it is not cleared. The same applies to truncation lengths and to the effect of writes made during a running command, all of which need an external model of the buffer.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  // byte addresses of the register space
  localparam logic [7:0] A_CTRL_B2 = 8'h02; // byte 2 of control word
  localparam logic [7:0] A_CSEL    = 8'h1D;
  localparam logic [7:0] A_OPC     = 8'h45;
  localparam logic [7:0] A_TRIG    = 8'h47;
  localparam logic [7:0] A_TXC     = 8'h48;
  localparam logic [7:0] A_RXC     = 8'h4B;
  localparam logic [7:0] A_STAT_B3 = 8'h4F; // byte 3 of status word
  localparam logic [7:0] A_BUF     = 8'h80;

  localparam int PCLR_BIT = 4; // word bit 20
  localparam int TRIG_BIT = 7;
  localparam int BUSY_BIT = 7; // word bit 31

  typedef enum logic [1:0] {
    PH_OPC = 2'd0,
    PH_TX  = 2'd1,
    PH_RX  = 2'd2
  } phase_t;

  // payload bytes actually sent
  function automatic int eff_tx(int req, int cap);
    return (req > cap) ? cap : req;
  endfunction

  // reply bytes actually taken, limited by remaining buffer room
  function automatic int eff_rx(int req, int tx_used, int cap);
    return (req > cap - tx_used) ? (cap - tx_used) : req;
  endfunction
endpackage

// File: rtl/spi_cmd_buf.sv
module spi_cmd_buf #(
  parameter int DEPTH = 64,
  parameter int PW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_we,
  input  logic [PW-1:0] a_waddr,
  input  logic [7:0]    a_wdata,
  input  logic [PW-1:0] a_raddr,
  output logic [7:0]    a_rdata,
  input  logic          b_we,
  input  logic [PW-1:0] b_waddr,
  input  logic [7:0]    b_wdata,
  input  logic [PW-1:0] b_raddr,
  output logic [7:0]    b_rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else begin
      if (a_we) mem[a_waddr] <= a_wdata;
      if (b_we) mem[b_waddr] <= b_wdata;
    end
  end

  assign a_rdata = mem[a_raddr];
  assign b_rdata = mem[b_raddr];

  // R11: bus writes are blocked while the engine may store
  p_single_writer_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_we && b_we));
endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
#(
  parameter int BUF_BYTES = 64,
  parameter int CS_W      = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_wr,
  input  logic [7:0]                    bus_addr,
  input  logic [7:0]                    bus_wdata,
  output logic [7:0]                    bus_rdata,
  input  logic                          busy,
  input  logic [7:0]                    buf_rdata,
  output logic [$clog2(BUF_BYTES)-1:0]  buf_addr,
  output logic                          buf_we,
  output logic [7:0]                    opcode,
  output logic [7:0]                    tx_cnt,
  output logic [7:0]                    rx_cnt,
  output logic [CS_W-1:0]               cs_field,
  output logic                          trig,
  output logic                          ptr_clr
);
  localparam int PW = $clog2(BUF_BYTES);

  logic in_buf;
  assign in_buf   = (int'(bus_addr) >= int'(A_BUF)) &&
                    ((int'(bus_addr) - int'(A_BUF)) < BUF_BYTES);
  assign buf_addr = PW'(bus_addr - A_BUF);
  assign buf_we   = bus_wr && in_buf && !busy;
  assign trig     = bus_wr && (bus_addr == A_TRIG) && bus_wdata[TRIG_BIT] && !busy;
  assign ptr_clr  = bus_wr && (bus_addr == A_CTRL_B2) && bus_wdata[PCLR_BIT] && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opcode   <= 8'h00;
      tx_cnt   <= 8'h00;
      rx_cnt   <= 8'h00;
      cs_field <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_OPC:   opcode   <= bus_wdata;
        A_TXC:   tx_cnt   <= bus_wdata;
        A_RXC:   rx_cnt   <= bus_wdata;
        A_CSEL:  cs_field <= bus_wdata[CS_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (in_buf) begin
      bus_rdata = buf_rdata;
    end else begin
      case (bus_addr)
        A_OPC:     bus_rdata = opcode;
        A_TXC:     bus_rdata = tx_cnt;
        A_RXC:     bus_rdata = rx_cnt;
        A_CSEL:    bus_rdata = {{(8-CS_W){1'b0}}, cs_field};
        A_STAT_B3: bus_rdata = {busy, 7'b0};
        default:   bus_rdata = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/spi_cmd_shift.sv
module spi_cmd_shift #(
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] start_byte,
  input  logic       start_tx,
  input  logic       next_valid,
  input  logic [7:0] next_byte,
  input  logic       next_tx,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       active,
  output logic       byte_done,
  output logic [7:0] rx_byte
);
  localparam int HALF = CLK_DIV / 2;
  localparam int DW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [DW-1:0] div_q;
  logic [2:0]    bit_q;
  logic [7:0]    tx_sh, rx_sh;
  logic          tx_en_q, sclk_q, act_q;
  logic          tick, rise, fall;

  assign tick      = act_q && (div_q == DW'(HALF - 1));
  assign rise      = tick && !sclk_q;
  assign fall      = tick && sclk_q;
  assign byte_done = fall && (bit_q == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      bit_q   <= 3'd0;
      tx_sh   <= 8'h00;
      rx_sh   <= 8'h00;
      tx_en_q <= 1'b0;
      sclk_q  <= 1'b0;
      act_q   <= 1'b0;
    end else if (start && !act_q) begin
      act_q   <= 1'b1;
      tx_sh   <= start_byte;
      tx_en_q <= start_tx;
      bit_q   <= 3'd0;
      div_q   <= '0;
      sclk_q  <= 1'b0;
    end else if (act_q) begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (rise) begin
        sclk_q <= 1'b1;
        rx_sh  <= {rx_sh[6:0], miso};
      end
      if (fall) begin
        sclk_q <= 1'b0;
        if (bit_q == 3'd7) begin
          if (next_valid) begin
            tx_sh   <= next_byte;
            tx_en_q <= next_tx;
            bit_q   <= 3'd0;
          end else begin
            act_q <= 1'b0;
          end
        end else begin
          tx_sh <= {tx_sh[6:0], 1'b0};
          bit_q <= bit_q + 3'd1;
        end
      end
    end
  end

  assign sclk    = sclk_q;
  assign mosi    = act_q && tx_en_q && tx_sh[7];
  assign active  = act_q;
  assign rx_byte = rx_sh;

  // R4: data launched only while the clock is low
  p_mosi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));
  // R4: clock rests low between commands
  p_sclk_rest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !sclk);
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
  import spi_cmd_pkg::*;
#(
  parameter int BUF_BYTES = 64,
  parameter int NCS       = 4,
  parameter int CS_W      = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          trig,
  input  logic                          ptr_clr,
  input  logic [7:0]                    opcode,
  input  logic [7:0]                    tx_cnt,
  input  logic [7:0]                    rx_cnt,
  input  logic [CS_W-1:0]               cs_field,
  input  logic                          byte_done,
  input  logic [7:0]                    rx_byte,
  input  logic                          shift_active,
  input  logic [7:0]                    buf_rdata,
  output logic                          busy,
  output logic                          start,
  output logic [7:0]                    start_byte,
  output logic                          next_valid,
  output logic [7:0]                    next_byte,
  output logic                          next_tx,
  output logic [$clog2(BUF_BYTES)-1:0]  buf_raddr,
  output logic                          buf_we,
  output logic [$clog2(BUF_BYTES)-1:0]  buf_waddr,
  output logic [7:0]                    buf_wdata,
  output logic [NCS-1:0]                cs_n,
  output logic                          rx_phase
);
  localparam int PW = $clog2(BUF_BYTES);
  localparam int CW = $clog2(BUF_BYTES + 1);

  function automatic logic [PW-1:0] ptr_inc(logic [PW-1:0] p);
    return (int'(p) == BUF_BYTES - 1) ? '0 : p + 1'b1;
  endfunction

  logic [CW-1:0]   rem_tx_q, rem_rx_q, tx_take, rx_take;
  logic [PW-1:0]   ptr_q;
  phase_t          phase_q;
  logic            busy_q, rx_any_q;
  logic [CS_W-1:0] cs_q;
  logic            have_tx, have_rx;

  assign tx_take = CW'(eff_tx(int'(tx_cnt), BUF_BYTES));
  assign rx_take = CW'(eff_rx(int'(rx_cnt), eff_tx(int'(tx_cnt), BUF_BYTES), BUF_BYTES));

  assign start      = trig && !busy_q;
  assign start_byte = opcode;
  assign have_tx    = (rem_tx_q != '0);
  assign have_rx    = (rem_rx_q != '0);
  assign next_valid = have_tx || have_rx;
  assign next_tx    = have_tx;
  assign next_byte  = have_tx ? buf_rdata : 8'h00;
  assign buf_raddr  = ptr_q;
  assign buf_we     = busy_q && byte_done && (phase_q == PH_RX);
  assign buf_waddr  = ptr_q;
  assign buf_wdata  = rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      phase_q  <= PH_OPC;
      rem_tx_q <= '0;
      rem_rx_q <= '0;
      ptr_q    <= '0;
      cs_q     <= '0;
      rx_any_q <= 1'b0;
    end else if (start) begin
      busy_q   <= 1'b1;
      phase_q  <= PH_OPC;
      rem_tx_q <= tx_take;
      rem_rx_q <= rx_take;
      cs_q     <= cs_field;
      rx_any_q <= (rx_take != '0);
    end else if (busy_q && byte_done) begin
      if (buf_we || have_tx) ptr_q <= ptr_inc(ptr_q);
      if (have_tx) begin
        rem_tx_q <= rem_tx_q - 1'b1;
        phase_q  <= PH_TX;
      end else if (have_rx) begin
        rem_rx_q <= rem_rx_q - 1'b1;
        phase_q  <= PH_RX;
      end else begin
        busy_q <= 1'b0;
      end
    end else if (!busy_q && ptr_clr) begin
      ptr_q <= '0;
    end
  end

  for (genvar k = 0; k < NCS; k++) begin : g_cs
    assign cs_n[k] = !(busy_q && (cs_q == CS_W'(k)));
  end

  assign busy     = busy_q;
  assign rx_phase = busy_q && (phase_q == PH_RX);

  // R3: sequencer and shifter agree on when a command runs
  p_busy_tracks_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q == shift_active);
  // R3: with replies pending, busy drops only after a store
  p_last_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_q) && rx_any_q) |-> $past(buf_we));
  // R6: exactly one target selected while busy, none when idle
  p_one_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> ($countones(~cs_n) == 1));
  p_idle_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (&cs_n));
  // R6: chip select does not move during a command
  p_cs_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(cs_n));
  // R10: pointer stays inside the buffer
  p_ptr_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr_q) < BUF_BYTES);
  // R9: truncated counts fit the buffer
  p_fit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && phase_q == PH_OPC) |-> (int'(rem_tx_q) + int'(rem_rx_q) <= BUF_BYTES));
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine #(
  parameter int CLK_DIV   = 4,
  parameter int BUF_BYTES = 64,
  parameter int NCS       = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic [7:0]     bus_addr,
  input  logic [7:0]     bus_wdata,
  output logic [7:0]     bus_rdata,
  output logic           sclk,
  output logic           mosi,
  input  logic           miso,
  output logic [NCS-1:0] cs_n
);
  localparam int PW   = $clog2(BUF_BYTES);
  localparam int CS_W = $clog2(NCS);

  logic [PW-1:0]   bus_baddr, eng_raddr, eng_waddr;
  logic [7:0]      bus_bdata, eng_rdata, eng_wdata;
  logic            bus_bwe, eng_we;
  logic [7:0]      opcode, tx_cnt, rx_cnt;
  logic [CS_W-1:0] cs_field;
  logic            trig, ptr_clr, busy;
  logic            start, next_valid, next_tx, byte_done, shift_active, rx_phase;
  logic [7:0]      start_byte, next_byte, rx_byte;
  logic            start_tx;

  assign start_tx = 1'b1;

  spi_cmd_regs #(.BUF_BYTES(BUF_BYTES), .CS_W(CS_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .buf_rdata(bus_bdata), .buf_addr(bus_baddr), .buf_we(bus_bwe),
    .opcode(opcode), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .cs_field(cs_field),
    .trig(trig), .ptr_clr(ptr_clr)
  );

  spi_cmd_buf #(.DEPTH(BUF_BYTES), .PW(PW)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .a_we(bus_bwe), .a_waddr(bus_baddr), .a_wdata(bus_wdata),
    .a_raddr(bus_baddr), .a_rdata(bus_bdata),
    .b_we(eng_we), .b_waddr(eng_waddr), .b_wdata(eng_wdata),
    .b_raddr(eng_raddr), .b_rdata(eng_rdata)
  );

  spi_cmd_seq #(.BUF_BYTES(BUF_BYTES), .NCS(NCS), .CS_W(CS_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .trig(trig), .ptr_clr(ptr_clr),
    .opcode(opcode), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .cs_field(cs_field),
    .byte_done(byte_done), .rx_byte(rx_byte), .shift_active(shift_active),
    .buf_rdata(eng_rdata), .busy(busy), .start(start), .start_byte(start_byte),
    .next_valid(next_valid), .next_byte(next_byte), .next_tx(next_tx),
    .buf_raddr(eng_raddr), .buf_we(eng_we), .buf_waddr(eng_waddr), .buf_wdata(eng_wdata),
    .cs_n(cs_n), .rx_phase(rx_phase)
  );

  spi_cmd_shift #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .start(start), .start_byte(start_byte), .start_tx(start_tx),
    .next_valid(next_valid), .next_byte(next_byte), .next_tx(next_tx),
    .miso(miso), .sclk(sclk), .mosi(mosi), .active(shift_active),
    .byte_done(byte_done), .rx_byte(rx_byte)
  );

  // R7: output held low while replies are clocked in
  p_mosi_quiet_rx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_phase |-> !mosi);
endmodule

// File: tb/tb_spi_cmd_engine.sv
module tb_spi_cmd_engine;
  localparam int DIV = 4;
  localparam int BUF = 64;

  logic       clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
  wire  [7:0] bus_rdata;
  wire        sclk, mosi;
  wire  [3:0] cs_n;
  logic       miso;

  always #4 clk = ~clk;

  spi_cmd_engine #(.CLK_DIV(DIV), .BUF_BYTES(BUF), .NCS(4)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs_n(cs_n)
  );

  int  checks = 0, errors = 0;
  bit  done = 0;
  int  salt = 0;
  logic [7:0] model_buf [BUF];
  int  model_ptr = 0;

  // slave/monitor state, written only by the monitor block
  int   tot = 0, cs_falls = 0, bad_gap = 0, cyc = 0, last_rise = 0;
  logic [7:0] cap [80];
  logic [3:0] cs_seen = 4'h0;
  logic prev_sclk = 1'b0, prev_idle = 1'b1;

  function automatic logic [7:0] resp(int k, int s);
    return 8'((k * 29 + s * 7 + 3) & 255);
  endfunction
  function automatic logic resp_bit(int t, int s);
    logic [7:0] b;
    b = resp(t / 8, s);
    return b[7 - (t % 8)];
  endfunction
  function automatic int x_tx(int r);
    if (r > BUF) return BUF;
    return r;
  endfunction
  function automatic int x_rx(int r, int t);
    int room;
    room = BUF - t;
    return (r < room) ? r : room;
  endfunction

  assign miso = resp_bit(tot, salt);

  always @(negedge clk) begin
    logic idle;
    idle = &cs_n;
    cyc++;
    if (prev_idle && !idle) begin
      tot = 0;
      cs_falls++;
      cs_seen = ~cs_n;
    end
    if (sclk && !prev_sclk && !idle) begin
      if (tot > 0 && (cyc - last_rise) != DIV) bad_gap++;
      last_rise = cyc;
      if (tot / 8 < 80) cap[tot / 8][7 - (tot % 8)] = mosi;
      tot++;
    end
    prev_sclk = sclk;
    prev_idle = idle;
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    int n;
    n = 0;
    do begin
      rd(8'h4F, v);
      n++;
    end while (v[7] && n < 20000);
  endtask

  logic [7:0] c_opc;
  int c_p0, c_te, c_re, c_cs, c_falls0;

  task automatic start_cmd(logic [7:0] opc, int tx, int rx, int cs, bit clr);
    logic [7:0] v;
    wr(8'h45, opc);
    wr(8'h48, 8'(tx));
    wr(8'h4B, 8'(rx));
    wr(8'h1D, 8'hFC | 8'(cs));
    if (clr) begin
      wr(8'h02, 8'h10);
      model_ptr = 0;
    end
    c_opc = opc; c_cs = cs; c_p0 = model_ptr;
    c_te = x_tx(tx); c_re = x_rx(rx, c_te);
    salt = int'($urandom % 256);
    c_falls0 = cs_falls;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h47; bus_wdata = 8'h80;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 8'h4F;
    #1 v = bus_rdata;
    chk("R3", "busy right after trigger", int'(v[7]), 1);
  endtask

  task automatic finish_cmd(string req);
    int total, bad, bval, bexp;
    logic [7:0] v, e;
    wait_idle();
    total = 1 + c_te + c_re;
    chk(req, "serial bit count", tot, 8 * total);
    chk("R6", "chip select assertions", cs_falls - c_falls0, 1);
    chk("R6", "selected target", int'(cs_seen), 1 << c_cs);
    bad = -1; bval = 0; bexp = 0;
    for (int k = 0; k < total && k < 80; k++) begin
      if (k == 0) e = c_opc;
      else if (k <= c_te) e = model_buf[(c_p0 + k - 1) % BUF];
      else e = 8'h00;
      if (bad < 0 && cap[k] !== e) begin bad = k; bval = int'(cap[k]); bexp = int'(e); end
    end
    chk((bad > c_te) ? "R7" : "R4", "mosi stream byte", bval, bexp);
    for (int j = 0; j < c_re; j++)
      model_buf[(c_p0 + c_te + j) % BUF] = resp(1 + c_te + j, salt);
    model_ptr = (c_p0 + c_te + c_re) % BUF;
    bad = -1; bval = 0; bexp = 0;
    for (int i = 0; i < BUF; i++) begin
      rd(8'(8'h80 + i), v);
      if (bad < 0 && v !== model_buf[i]) begin bad = i; bval = int'(v); bexp = int'(model_buf[i]); end
    end
    chk("R5", "buffer contents after command", bval, bexp);
  endtask

  task automatic fill_buf();
    logic [7:0] d;
    for (int i = 0; i < BUF; i++) begin
      d = 8'($urandom);
      wr(8'(8'h80 + i), d);
      model_buf[i] = d;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "cs_n at reset", int'(cs_n), 15);
    chk("R1", "sclk at reset", int'(sclk), 0);
    chk("R1", "mosi at reset", int'(mosi), 0);
    rd(8'h4F, v); chk("R1", "status at reset", int'(v), 0);
    rst_n = 1'b1;
    rd(8'h45, v); chk("R1", "opcode reg at reset", int'(v), 0);
    rd(8'h48, v); chk("R1", "tx count at reset", int'(v), 0);
    rd(8'h4B, v); chk("R1", "rx count at reset", int'(v), 0);
    rd(8'h1D, v); chk("R1", "cs reg at reset", int'(v), 0);
    // R2: register map
    wr(8'h1D, 8'hFF); rd(8'h1D, v); chk("R2", "cs field upper bits", int'(v), 3);
    wr(8'h48, 8'h37); rd(8'h48, v); chk("R2", "tx count readback", int'(v), 8'h37);
    fill_buf();
    rd(8'h80 + 8'd17, v); chk("R2", "buffer byte 17", int'(v), int'(model_buf[17]));
    rd(8'h80 + 8'd63, v); chk("R2", "buffer byte 63", int'(v), int'(model_buf[63]));

    // R8: opcode only, then tx without rx, then rx without tx
    start_cmd(8'hA5, 0, 0, 0, 1); finish_cmd("R8");
    start_cmd(8'h5A, 3, 0, 1, 1); finish_cmd("R8");
    start_cmd(8'h0F, 0, 4, 2, 1); finish_cmd("R8");
    // R5: mixed command
    start_cmd(8'hC3, 2, 3, 3, 1); finish_cmd("R5");
    // R10: no clear, pointer continues from 5
    chk("R10", "model pointer before continuation", model_ptr, 5);
    start_cmd(8'h33, 2, 2, 2, 0); finish_cmd("R10");
    // R9: truncation
    start_cmd(8'h11, 60, 10, 0, 1); finish_cmd("R9");
    start_cmd(8'h22, 200, 5, 1, 1); finish_cmd("R9");

    // R11: activity while busy
    fill_buf();
    start_cmd(8'h3C, 2, 2, 1, 1);
    wr(8'h80 + 8'd10, 8'hEE);
    wr(8'h45, 8'h99);
    wr(8'h47, 8'h80);
    wr(8'h02, 8'h10);
    finish_cmd("R11");
    rd(8'h45, v); chk("R11", "opcode reg accepted while busy", int'(v), 8'h99);
    // pointer clear during busy ignored: continues from 4
    chk("R11", "model pointer after ignored clear", model_ptr, 4);
    start_cmd(8'h99, 1, 1, 2, 0); finish_cmd("R10");

    // random commands
    for (int n = 0; n < 20; n++) begin
      start_cmd(8'($urandom), int'($urandom % 8), int'($urandom % 8),
                int'($urandom % 4), ($urandom % 3) != 0);
      finish_cmd("R4");
    end
    chk("R4", "rising edge spacing violations", bad_gap, 0);
    chk("R1", "cs_n idle at end", int'(cs_n), 15);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule